// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block translates a 32-bit virtual address into a physical address. A small fully associative translation cache sits in front of it. On a miss, the block reads a first-level descriptor and then a page descriptor from memory, with no software help. The first-level descriptor is found from the table base input. The page descriptor is found from the coarse-table base that the first-level descriptor holds.

The result of the walk goes into the translation cache. The walk also returns the page's cacheable and bufferable bits, or a fault. A fault is either a translation fault (an empty descriptor at either level) or a permission fault. A permission fault means the page's access field does not allow the request's privilege and direction.

Only one request is handled at a time. `req_ready` is high only while the block is idle. Each accepted request gets exactly one single-cycle `rsp_valid` pulse. A `flush` pulse empties the translation cache.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: On a miss, the first memory read uses address {ttb[31:14], va[31:20], 2'b00}. `mem_req` and `mem_addr` hold steady until `mem_rvalid` arrives.
- R3: The second read uses address {first_desc[31:10], va[19:12], 2'b00}.
- R4: The page descriptor has this layout: [31:12] page frame, [5:4] access field, [3] cacheable, [2] bufferable, [1:0] type. A permitted result gives pa = {page_desc[31:12], va[11:0]}, with `rsp_cache` = bit 3 and `rsp_buffer` = bit 2.
- R5: A cache hit makes no memory read. It responds in the cycle after the request is accepted.
- R6: A descriptor with type [1:0] = 00 at either level ends the walk with a translation fault (`rsp_fault`=1, `rsp_perm_fault`=0) and does not fill the cache. The same page walks again on its next access.
- R7: The access field is checked on hits and on walks alike:
  - 00 allows nothing.
  - 01 allows privileged access only (`req_user`=0).
  - 10 allows privileged access of either kind, and user reads.
  - 11 allows everything.
  A denied request gives `rsp_fault`=1 and `rsp_perm_fault`=1. Any fault drives pa, cache and buffer to 0.
- R8: The cache has 8 entries, refilled in round-robin order. After a flush, the ninth distinct page that is filled evicts the first page that was filled.
- R9: `flush` invalidates every entry, so previously cached pages walk again.
- R10: Only one walk is in flight. `req_ready` is 0 whenever `mem_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all translation cache entries |
| ttb | input | 32 | Physical base of first-level table (16 KB aligned) |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = unprivileged access |
| mem_req | output | 1 | Descriptor read request, held until answered |
| mem_addr | output | 32 | Descriptor address |
| mem_rvalid | input | 1 | Descriptor data valid |
| mem_rdata | input | 32 | Descriptor data |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_pa | output | 32 | Physical address |
| rsp_cache | output | 1 | Cacheable attribute |
| rsp_buffer | output | 1 | Bufferable attribute |
| rsp_fault | output | 1 | Request faulted |
| rsp_perm_fault | output | 1 | Fault was a permission fault |

## Verification
The properties assume that memory raises `mem_rvalid` only while `mem_req` is high, and for exactly one cycle per read. The bench's responder follows this: it answers each read after a fixed delay and stays silent between reads. The properties also assume that `req_valid` is meaningful only when `req_ready` is high. The driver enforces this by waiting for `req_ready` and holding `req_valid` for one cycle. `flush` is never pulsed during a walk or in the same cycle as a request, so each check expects a clean miss or hit.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int ADDR_W   = 32;
    localparam int OFF_W    = 12;
    localparam int PN_W     = ADDR_W - OFF_W;
    localparam int TBASE_LO = 14;
    localparam int CBASE_LO = 10;

    typedef enum logic [1:0] {
        AP_NONE    = 2'b00,
        AP_PRIV    = 2'b01,
        AP_USER_RO = 2'b10,
        AP_FULL    = 2'b11
    } ap_e;

    typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2} walk_st_e;

    typedef struct packed {
        logic [PN_W-1:0] vpn;
        logic [PN_W-1:0] ppn;
        logic            cache;
        logic            buf_en;
        ap_e             ap;
    } tlb_ent_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pa;
        logic              cache;
        logic              buf_en;
        logic              fault;
        logic              perm;
    } rsp_t;

    function automatic logic [ADDR_W-1:0] l1_desc_addr(input logic [ADDR_W-1:0] base,
                                                       input logic [ADDR_W-1:0] va);
        return {base[ADDR_W-1:TBASE_LO], va[31:20], 2'b00};
    endfunction

    function automatic logic [ADDR_W-1:0] l2_desc_addr(input logic [ADDR_W-1:0] l1d,
                                                       input logic [ADDR_W-1:0] va);
        return {l1d[ADDR_W-1:CBASE_LO], va[19:12], 2'b00};
    endfunction

    function automatic logic desc_present(input logic [ADDR_W-1:0] d);
        return d[1:0] != 2'b00;
    endfunction

    function automatic tlb_ent_t page_entry(input logic [ADDR_W-1:0] va,
                                            input logic [ADDR_W-1:0] d);
        tlb_ent_t e;
        e.vpn    = va[ADDR_W-1:OFF_W];
        e.ppn    = d[ADDR_W-1:OFF_W];
        e.cache  = d[3];
        e.buf_en = d[2];
        e.ap     = ap_e'(d[5:4]);
        return e;
    endfunction

    function automatic rsp_t make_rsp(input tlb_ent_t e, input logic [OFF_W-1:0] off,
                                      input logic allow);
        rsp_t r;
        r = '0;
        if (allow) begin
            r.pa     = {e.ppn, off};
            r.cache  = e.cache;
            r.buf_en = e.buf_en;
        end else begin
            r.fault = 1'b1;
            r.perm  = 1'b1;
        end
        return r;
    endfunction

    function automatic rsp_t xlate_fault_rsp();
        rsp_t r;
        r = '0;
        r.fault = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/xw_tlb.sv
module xw_tlb
    import xw_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [PN_W-1:0] lk_vpn,
    input  logic            fill_en,
    input  tlb_ent_t        fill_ent,
    output logic            hit,
    output tlb_ent_t        hit_ent
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_ent_t           ent_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   victim_q;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
            assign match[i] = valid_q[i] && (ent_q[i].vpn == lk_vpn);
        end
    endgenerate

    always_comb begin
        hit     = |match;
        hit_ent = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_ent = tlb_ent_t'(hit_ent | ent_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            victim_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[victim_q] <= 1'b1;
            victim_q <= (victim_q == IDX_W'(ENTRIES - 1)) ? '0 : victim_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!flush && fill_en) ent_q[victim_q] <= fill_ent;
    end
endmodule

// File: rtl/xw_access_check.sv
module xw_access_check
    import xw_pkg::*;
(
    input  ap_e  ap,
    input  logic write,
    input  logic user,
    output logic allow
);
    always_comb begin
        unique case (ap)
            AP_NONE:    allow = 1'b0;
            AP_PRIV:    allow = !user;
            AP_USER_RO: allow = !user || !write;
            AP_FULL:    allow = 1'b1;
            default:    allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/xw_walk_ctrl.sv
module xw_walk_ctrl
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_va,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] ttb,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              tlb_hit,
    input  tlb_ent_t          tlb_hit_ent,
    input  logic              allow,
    output logic              req_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PN_W-1:0]   lk_vpn,
    output logic              fill_en,
    output tlb_ent_t          fill_ent,
    output ap_e               chk_ap,
    output logic              chk_write,
    output logic              chk_user,
    output logic              rsp_valid,
    output rsp_t              rsp
);
    walk_st_e          st_q;
    logic [ADDR_W-1:0] va_q, base_q, l1_q;
    logic              wr_q, user_q;

    assign req_ready = (st_q == ST_IDLE);
    assign mem_req   = (st_q != ST_IDLE);
    assign mem_addr  = (st_q == ST_L1) ? l1_desc_addr(base_q, va_q) : l2_desc_addr(l1_q, va_q);
    assign lk_vpn    = req_va[ADDR_W-1:OFF_W];
    assign fill_ent  = page_entry(va_q, mem_rdata);
    assign fill_en   = (st_q == ST_L2) && mem_rvalid && desc_present(mem_rdata);

    always_comb begin
        if (st_q == ST_IDLE) begin
            chk_ap    = tlb_hit_ent.ap;
            chk_write = req_write;
            chk_user  = req_user;
        end else begin
            chk_ap    = fill_ent.ap;
            chk_write = wr_q;
            chk_user  = user_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            rsp_valid <= 1'b0;
            rsp       <= '0;
            va_q      <= '0;
            base_q    <= '0;
            l1_q      <= '0;
            wr_q      <= 1'b0;
            user_q    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_va;
                    wr_q   <= req_write;
                    user_q <= req_user;
                    base_q <= ttb;
                    if (tlb_hit) begin
                        rsp_valid <= 1'b1;
                        rsp       <= make_rsp(tlb_hit_ent, req_va[OFF_W-1:0], allow);
                    end else begin
                        st_q <= ST_L1;
                    end
                end
                ST_L1: if (mem_rvalid) begin
                    if (desc_present(mem_rdata)) begin
                        l1_q <= mem_rdata;
                        st_q <= ST_L2;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp       <= xlate_fault_rsp();
                        st_q      <= ST_IDLE;
                    end
                end
                ST_L2: if (mem_rvalid) begin
                    rsp_valid <= 1'b1;
                    rsp       <= desc_present(mem_rdata) ?
                                 make_rsp(fill_ent, va_q[OFF_W-1:0], allow) : xlate_fault_rsp();
                    st_q      <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xw_pkg::*;
#(
    parameter int TLB_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] ttb,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic              req_write,
    input  logic              req_user,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_cache,
    output logic              rsp_buffer,
    output logic              rsp_fault,
    output logic              rsp_perm_fault
);
    logic            tlb_hit, fill_en, allow, chk_write, chk_user;
    tlb_ent_t        tlb_hit_ent, fill_ent;
    logic [PN_W-1:0] lk_vpn;
    ap_e             chk_ap;
    rsp_t            rsp;

    xw_tlb #(.ENTRIES(TLB_ENTRIES)) i_tlb (
        .clk(clk), .rst(rst), .flush(flush), .lk_vpn(lk_vpn),
        .fill_en(fill_en), .fill_ent(fill_ent), .hit(tlb_hit), .hit_ent(tlb_hit_ent)
    );

    xw_access_check i_perm (
        .ap(chk_ap), .write(chk_write), .user(chk_user), .allow(allow)
    );

    xw_walk_ctrl i_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_user(req_user), .ttb(ttb),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tlb_hit(tlb_hit),
        .tlb_hit_ent(tlb_hit_ent), .allow(allow), .req_ready(req_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .lk_vpn(lk_vpn),
        .fill_en(fill_en), .fill_ent(fill_ent), .chk_ap(chk_ap),
        .chk_write(chk_write), .chk_user(chk_user), .rsp_valid(rsp_valid), .rsp(rsp)
    );

    assign rsp_pa         = rsp.pa;
    assign rsp_cache      = rsp.cache;
    assign rsp_buffer     = rsp.buf_en;
    assign rsp_fault      = rsp.fault;
    assign rsp_perm_fault = rsp.perm;
endmodule

// File: rtl/xw_checker.sv
module xw_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic        rsp_valid,
    input logic [31:0] rsp_pa,
    input logic        rsp_cache,
    input logic        rsp_buffer,
    input logic        rsp_fault,
    input logic        rsp_perm_fault
);
    AST_SINGLE_WALK: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready); // R10

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R2

    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_pa == 32'd0 && !rsp_cache && !rsp_buffer)); // R7

    AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rvalid))); // R5

    AST_PERM_IMPLIES_FAULT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_perm_fault) |-> rsp_fault); // R7
endmodule

bind xlate_walker xw_checker i_xw_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_cache(rsp_cache),
    .rsp_buffer(rsp_buffer), .rsp_fault(rsp_fault), .rsp_perm_fault(rsp_perm_fault)
);

// File: tb/test_xlate_walker.sv
module test_xlate_walker;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TTB = 32'h0010_0000;
    localparam logic [31:0] CT_BASE = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic        rsp_cache, rsp_buffer, rsp_fault, rsp_perm_fault;

    xlate_walker i_xlate_walker (
        .clk(clk), .rst(rst), .flush(flush), .ttb(TTB), .req_valid(req_valid),
        .req_ready(req_ready), .req_va(req_va), .req_write(req_write), .req_user(req_user),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_cache(rsp_cache), .rsp_buffer(rsp_buffer),
        .rsp_fault(rsp_fault), .rsp_perm_fault(rsp_perm_fault)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [31:0] pa;
        logic        c, b, fault, perm;
        int          reads;
        logic [31:0] a1, a2;
        string       req;
    } item_t;

    item_t       exp_q[$];
    logic [31:0] mem_img [logic [31:0]];
    int          checks = 0, fails = 0, resp_cnt = 0, cyc = 0, acc_cyc = 0;
    int          reads = 0, ready_viol = 0, lat_cnt = 0;
    logic [31:0] rd_addr [2];
    logic [31:0] addr_q = '0;
    bit          busy = 0, done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic logic [31:0] ct_of(input logic [31:0] va);
        return CT_BASE + ({20'd0, va[31:20]} << 10);
    endfunction
    function automatic logic [31:0] a1_of(input logic [31:0] va);
        return {TTB[31:14], va[31:20], 2'b00};
    endfunction
    function automatic logic [31:0] a2_of(input logic [31:0] va);
        logic [31:0] ct;
        ct = ct_of(va);
        return {ct[31:10], va[19:12], 2'b00};
    endfunction

    // Descriptor layout per R4: [31:12] frame, [5:4] access, [3] C, [2] B, [1:0] type
    task automatic map_l1(input logic [31:0] va);
        logic [31:0] ct;
        ct = ct_of(va);
        mem_img[a1_of(va)] = {ct[31:10], 8'd0, 2'b01};
    endtask
    task automatic map_page(input logic [31:0] va, input logic [19:0] ppn,
                            input logic c, input logic b, input logic [1:0] ap);
        map_l1(va);
        mem_img[a2_of(va)] = {ppn, 6'd0, ap, c, b, 2'b10};
    endtask

    function automatic logic allowed(input logic [1:0] ap, input logic wr, input logic user);
        case (ap)
            2'b00:   return 1'b0;
            2'b01:   return !user;
            2'b10:   return !user || !wr;
            default: return 1'b1;
        endcase
    endfunction

    task automatic access(input logic [31:0] va, input logic wr, input logic user,
                          input int exp_reads, input string req);
        item_t it;
        logic [31:0] d1, d2;
        int tgt;
        it.req = req;
        it.reads = exp_reads;
        it.a1 = a1_of(va);
        it.a2 = a2_of(va);
        it.pa = '0; it.c = 0; it.b = 0; it.fault = 1; it.perm = 0;
        d1 = mem_img.exists(it.a1) ? mem_img[it.a1] : 32'd0;
        d2 = mem_img.exists(it.a2) ? mem_img[it.a2] : 32'd0;
        if (d1[1:0] != 2'b00 && d2[1:0] != 2'b00) begin
            if (allowed(d2[5:4], wr, user)) begin
                it.fault = 0;
                it.pa = {d2[31:12], va[11:0]};
                it.c = d2[3];
                it.b = d2[2];
            end else begin
                it.perm = 1;
            end
        end
        exp_q.push_back(it);
        tgt = resp_cnt + 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_va = va; req_write = wr; req_user = user; req_valid = 1'b1;
        acc_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        wait (resp_cnt >= tgt);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Monitor first, then memory responder, all on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && req_ready) ready_viol++;
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R10", "response with no request outstanding");
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(rsp_pa == it.pa && rsp_cache == it.c && rsp_buffer == it.b &&
                          rsp_fault == it.fault && rsp_perm_fault == it.perm, it.req,
                          $sformatf("result pa=%h c=%b b=%b f=%b p=%b expected pa=%h c=%b b=%b f=%b p=%b",
                                    rsp_pa, rsp_cache, rsp_buffer, rsp_fault, rsp_perm_fault,
                                    it.pa, it.c, it.b, it.fault, it.perm));
                    check(reads == it.reads, it.req,
                          $sformatf("descriptor reads %0d expected %0d", reads, it.reads));
                    if (it.reads >= 1)
                        check(rd_addr[0] == it.a1, "R2",
                              $sformatf("first read addr %h expected %h", rd_addr[0], it.a1));
                    if (it.reads == 2)
                        check(rd_addr[1] == it.a2, "R3",
                              $sformatf("second read addr %h expected %h", rd_addr[1], it.a2));
                    if (it.reads == 0)
                        check(cyc - acc_cyc == 1, "R5",
                              $sformatf("hit latency %0d expected 1", cyc - acc_cyc));
                end
                reads = 0;
                resp_cnt++;
            end
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
            end else if (busy) begin
                if (lat_cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = mem_img.exists(addr_q) ? mem_img[addr_q] : 32'd0;
                    busy = 0;
                end else begin
                    lat_cnt--;
                end
            end else if (mem_req) begin
                busy = 1;
                addr_q = mem_addr;
                lat_cnt = 1;
                if (reads < 2) rd_addr[reads] = mem_addr;
                reads++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, actual incomplete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    localparam logic [31:0] VA_A = 32'h1234_5678;
    localparam logic [31:0] VA_B = 32'h0AB0_1234;
    localparam logic [31:0] VA_C = 32'h7770_3000;
    localparam logic [31:0] VA_N = 32'h5550_0000;
    localparam logic [31:0] VA_U = 32'h3210_0ABC;
    localparam logic [31:0] VA_E = 32'h0AB0_9FFF;

    initial begin
        map_page(VA_A, 20'hABCDE, 1'b1, 1'b0, 2'b11);
        map_page(VA_B, 20'h11111, 1'b0, 1'b1, 2'b01);
        map_page(VA_C, 20'h22222, 1'b1, 1'b1, 2'b10);
        map_page(VA_N, 20'h33333, 1'b1, 1'b1, 2'b00);
        map_l1(VA_E);
        for (int i = 0; i < 9; i++)
            map_page(32'h6000_0000 + (i << 12), 20'h80000 + 20'(i), 1'b0, 1'b0, 2'b11);

        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req, "R1",
              $sformatf("in reset ready=%b rsp=%b mreq=%b expected 1 0 0", req_ready, rsp_valid, mem_req));
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req, "R1",
              $sformatf("after reset ready=%b rsp=%b mreq=%b expected 1 0 0", req_ready, rsp_valid, mem_req));

        access(VA_A, 1'b0, 1'b1, 2, "R4");                // miss, full walk
        access(VA_A ^ 32'h0000_0FFF, 1'b1, 1'b1, 0, "R5"); // hit, other offset
        access(VA_B, 1'b0, 1'b1, 2, "R7");                // privileged-only, user -> perm fault, filled
        access(VA_B, 1'b1, 1'b0, 0, "R7");                // privileged write on hit
        access(VA_C, 1'b1, 1'b1, 2, "R7");                // user write to read-only
        access(VA_C, 1'b0, 1'b1, 0, "R7");                // user read hit
        access(VA_C, 1'b1, 1'b0, 0, "R7");                // privileged write hit
        access(VA_N, 1'b0, 1'b0, 2, "R7");                // no access at all
        access(VA_U, 1'b0, 1'b0, 1, "R6");                // empty first level
        access(VA_U, 1'b0, 1'b0, 1, "R6");                // not filled, walks again
        access(VA_E, 1'b0, 1'b0, 2, "R6");                // empty page descriptor
        access(VA_E, 1'b0, 1'b0, 2, "R6");                // not filled, walks again

        do_flush();
        access(VA_A, 1'b0, 1'b0, 2, "R9");                // flushed, walks again

        do_flush();
        for (int i = 0; i < 8; i++)
            access(32'h6000_0000 + (i << 12), 1'b0, 1'b0, 2, "R8");
        for (int i = 0; i < 8; i++)
            access(32'h6000_0010 + (i << 12), 1'b0, 1'b0, 0, "R8");
        access(32'h6000_8000, 1'b0, 1'b0, 2, "R8");       // ninth page, evicts page 0
        access(32'h6000_2000, 1'b0, 1'b0, 0, "R8");       // page 2 still resident
        access(32'h6000_0000, 1'b0, 1'b0, 2, "R8");       // page 0 was evicted
        access(32'h6000_1000, 1'b0, 1'b0, 2, "R8");       // refill of page 0 evicted page 1

        repeat (3) @(negedge clk);
        check(ready_viol == 0, "R10",
              $sformatf("cycles with mem_req and req_ready both high %0d expected 0", ready_viol));
        check(exp_q.size() == 0, "R10",
              $sformatf("responses missing %0d expected 0", exp_q.size()));
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule